// File: doc/BRIEF.md
# Carry-Preserving Increment Flag Unit

This block is the execute-stage datapath for an add-by-one operation. It takes a 64-bit operand, a width code that picks an 8, 16, 32 or 64-bit operation, the current carry flag and a valid strobe. One clock later it presents the incremented value, truncated to the chosen width, and a fresh set of six arithmetic flags, together with an output valid.

The carry flag is not recomputed. It is copied from the input, even when the value wraps from all ones to zero. This lets a loop counter step without disturbing a carry chain held in the flags. Overflow, sign, zero, half-carry and parity are derived from the result at the selected width. Result bits above that width are driven to zero. Merging them with the old register contents is left to the writeback logic.

Top module: `inc_flag_unit`

## Requirements
- R1: For a width code of 0, 1, 2 or 3 (8, 16, 32 or 64 bits), `out_result` equals `in_operand + 1` taken modulo 2 to the power of the width.
- R2: The flags bus is laid out as bit 0 carry, bit 1 parity, bit 2 half-carry, bit 3 zero, bit 4 sign and bit 5 overflow. Carry out (bit 0) always equals `in_carry` as sampled with the strobe, including on a wrap to zero.
- R3: Overflow (bit 5) is set exactly when the operand, at the selected width, equals the largest positive signed value (7Fh, 7FFFh, 7FFFFFFFh or 7FFF...Fh).
- R4: Sign (bit 4) equals the top bit of the result at the selected width. Zero (bit 3) is set exactly when every result bit within the width is zero.
- R5: Bits of `out_result` above the selected width are zero.
- R6: Half-carry (bit 2) is set exactly when operand bits 3:0 are all ones. Parity (bit 1) is set exactly when result bits 7:0 hold an even number of ones.
- R7: Result and flags appear one clock after `in_valid` with `out_valid` high. Strobes on consecutive cycles give results on consecutive cycles.
- R8: Reset clears `out_valid`, `out_result` and `out_flags`. In a cycle without `in_valid`, `out_result` and `out_flags` keep their values and `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Value to increment |
| in_width | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Incremented value, zero above the width |
| out_flags | output | 6 | Updated flags, layout as in R2 |

## Verification
The assertions check four things on every cycle. Carry is copied from the previous strobe's input, and an 8-bit result never spills above bit 7. Zero and sign are never set together, and overflow always comes with sign. The valid pipeline and the hold behaviour when idle are also checked each cycle. The exact arithmetic needs the bench's directed scenarios. These are the wrap at each width, the signed boundary that sets overflow, the half-carry nibble and parity patterns, and the masking of stale upper operand bits.

// File: rtl/inc_pkg.sv
package inc_pkg;

    // Width codes; the code value is the log2 of (width / 8)
    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } size_e;

    // Packed so that carry is bit 0 and overflow is bit 5
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    localparam int unsigned FLAG_W   = $bits(flags_t);
    localparam int unsigned SIZE_CNT = 4;

endpackage

// File: rtl/inc_size_lanes.sv
module inc_size_lanes
    import inc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] sum,
    input  size_e             size,
    output logic [DATA_W-1:0] mask,
    output logic              op_msb,
    output logic              res_msb
);

    logic [SIZE_CNT-1:0][DATA_W-1:0] lane_mask;
    logic [SIZE_CNT-1:0]             lane_op_msb;
    logic [SIZE_CNT-1:0]             lane_res_msb;

    // One lane per supported width; each lane knows its mask and top bit
    for (genvar i = 0; i < SIZE_CNT; i++) begin : g_lane
        localparam int unsigned LANE_W = 8 << i;
        if (LANE_W >= DATA_W) begin : g_full
            assign lane_mask[i]    = {DATA_W{1'b1}};
            assign lane_op_msb[i]  = operand[DATA_W-1];
            assign lane_res_msb[i] = sum[DATA_W-1];
        end else begin : g_part
            assign lane_mask[i]    = {DATA_W{1'b1}} >> (DATA_W - LANE_W);
            assign lane_op_msb[i]  = operand[LANE_W-1];
            assign lane_res_msb[i] = sum[LANE_W-1];
        end
    end

    always_comb begin
        mask    = lane_mask[size];
        op_msb  = lane_op_msb[size];
        res_msb = lane_res_msb[size];
    end

endmodule

// File: rtl/inc_flag_gen.sv
module inc_flag_gen
    import inc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] operand,
    input  size_e             size,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] mask;
    logic              op_msb;
    logic              res_msb;

    assign sum = operand + {{(DATA_W-1){1'b0}}, 1'b1};

    inc_size_lanes #(
        .DATA_W (DATA_W)
    ) i_lanes (
        .operand (operand),
        .sum     (sum),
        .size    (size),
        .mask    (mask),
        .op_msb  (op_msb),
        .res_msb (res_msb)
    );

    always_comb begin
        result    = sum & mask;
        // Sign flips from clear to set only at the largest positive value
        flags.ovf = res_msb & ~op_msb;
        flags.sgn = res_msb;
        flags.zro = ~|result;
        flags.aux = &operand[3:0];
        flags.par = ~^sum[7:0];
        flags.cry = carry_in;
    end

endmodule

// File: rtl/inc_flag_unit.sv
module inc_flag_unit
    import inc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_operand,
    input  logic [1:0]        in_width,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [FLAG_W-1:0] out_flags
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        flags_t            flg;
    } stage_t;

    stage_t            stage_d, stage_q;
    logic [DATA_W-1:0] gen_result;
    flags_t            gen_flags;

    inc_flag_gen #(
        .DATA_W (DATA_W)
    ) i_gen (
        .operand  (in_operand),
        .size     (size_e'(in_width)),
        .carry_in (in_carry),
        .result   (gen_result),
        .flags    (gen_flags)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res = gen_result;
            stage_d.flg = gen_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.vld;
    assign out_result = stage_q.res;
    assign out_flags  = stage_q.flg;

    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_flags[0] == $past(in_carry)); // R2

    AST_OVF_HAS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_flags[5] |-> out_flags[4]); // R3

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_flags[3] && out_flags[4])); // R4

    AST_BYTE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_width) == 2'd0 |-> out_result[DATA_W-1:8] == '0); // R5

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_flags)); // R8

endmodule

// File: tb/test_inc_flag_unit.sv
module test_inc_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_width = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    inc_flag_unit i_inc_flag_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_width   (in_width),
        .in_carry   (in_carry),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_flags  (out_flags)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic logic [63:0] ref_result(logic [63:0] op, logic [1:0] w);
        int bits = 8 << w;
        logic [63:0] m = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
        return (op + 64'd1) & m;
    endfunction

    function automatic logic [5:0] ref_flags(logic [63:0] op, logic [1:0] w, logic c);
        int bits = 8 << w;
        logic [63:0] m = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
        logic [63:0] r = (op + 64'd1) & m;
        logic [5:0] f;
        f[0] = c;
        f[1] = ($countones(r[7:0]) % 2) == 0;
        f[2] = (op[3:0] == 4'hF);
        f[3] = (r == 64'd0);
        f[4] = r[bits-1];
        f[5] = ((op & m) == (m >> 1));
        return f;
    endfunction

    task automatic drive(input logic [63:0] op, input logic [1:0] w, input logic c);
        in_valid   = 1'b1;
        in_operand = op;
        in_width   = w;
        in_carry   = c;
    endtask

    task automatic expect_out(input logic [63:0] op, input logic [1:0] w, input logic c, input string req);
        check({63'd0, out_valid}, 64'd1, {req, " R7 valid"});
        check(out_result, ref_result(op, w), {req, " R1 result"});
        check({58'd0, out_flags}, {58'd0, ref_flags(op, w, c)}, {req, " flags"});
    endtask

    // One strobe, result checked one clock later
    task automatic run_vec(input logic [63:0] op, input logic [1:0] w, input logic c, input string req);
        @(negedge clk);
        drive(op, w, c);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out(op, w, c, req);
    endtask

    task automatic t_reset;
        check({63'd0, out_valid}, 64'd0, "R8 reset valid");
        check(out_result, 64'd0, "R8 reset result");
        check({58'd0, out_flags}, 64'd0, "R8 reset flags");
    endtask

    task automatic t_basic;
        run_vec(64'h0000_0000_0000_0041, 2'd0, 1'b0, "R1 byte");
        run_vec(64'h0000_0000_0000_1233, 2'd1, 1'b1, "R1 half");
        run_vec(64'h0000_0000_8000_0000, 2'd2, 1'b0, "R4 word neg");
        run_vec(64'h1234_5678_9ABC_DEF0, 2'd3, 1'b1, "R1 double");
    endtask

    task automatic t_wrap;
        run_vec(64'h0000_0000_0000_00FF, 2'd0, 1'b0, "R2 wrap c0");
        check({63'd0, out_flags[0]}, 64'd0, "R2 carry kept 0");
        check({63'd0, out_flags[3]}, 64'd1, "R4 zero on wrap");
        run_vec(64'h0000_0000_0000_00FF, 2'd0, 1'b1, "R2 wrap c1");
        check({63'd0, out_flags[0]}, 64'd1, "R2 carry kept 1");
        run_vec(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, "R2 double wrap");
        run_vec(64'h0000_0000_FFFF_FFFF, 2'd2, 1'b1, "R2 word wrap");
    endtask

    task automatic t_overflow;
        run_vec(64'h0000_0000_0000_007F, 2'd0, 1'b0, "R3 byte");
        check({63'd0, out_flags[5]}, 64'd1, "R3 byte ovf set");
        run_vec(64'h0000_0000_0000_7FFF, 2'd1, 1'b0, "R3 half");
        run_vec(64'h0000_0000_7FFF_FFFF, 2'd2, 1'b0, "R3 word");
        run_vec(64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, "R3 double");
        run_vec(64'h0000_0000_0000_7FFF, 2'd2, 1'b0, "R3 not max at word");
        check({63'd0, out_flags[5]}, 64'd0, "R3 word ovf clear");
        run_vec(64'h0000_0000_0000_00FE, 2'd0, 1'b0, "R3 neg no ovf");
    endtask

    task automatic t_aux_parity;
        run_vec(64'h0000_0000_0000_000F, 2'd0, 1'b0, "R6 nibble carry");
        check({63'd0, out_flags[2]}, 64'd1, "R6 aux set");
        run_vec(64'h0000_0000_0000_000E, 2'd0, 1'b0, "R6 no nibble carry");
        check({63'd0, out_flags[2]}, 64'd0, "R6 aux clear");
        run_vec(64'h0000_0000_0000_0002, 2'd1, 1'b0, "R6 parity even");
        check({63'd0, out_flags[1]}, 64'd1, "R6 parity set");
        run_vec(64'h0000_0000_0000_0003, 2'd1, 1'b0, "R6 parity odd");
        check({63'd0, out_flags[1]}, 64'd0, "R6 parity clear");
    endtask

    task automatic t_mask;
        run_vec(64'hDEAD_BEEF_CAFE_1234, 2'd0, 1'b0, "R5 byte");
        check(out_result >> 8, 64'd0, "R5 above byte");
        run_vec(64'hDEAD_BEEF_CAFE_FFFF, 2'd1, 1'b1, "R5 half");
        check(out_result >> 16, 64'd0, "R5 above half");
        run_vec(64'hDEAD_BEEF_7FFF_FFFE, 2'd2, 1'b0, "R5 word");
        check(out_result >> 32, 64'd0, "R5 above word");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(64'h10, 2'd0, 1'b1);
        @(negedge clk);
        expect_out(64'h10, 2'd0, 1'b1, "R7 first");
        drive(64'hFFFF, 2'd1, 1'b0);
        @(negedge clk);
        expect_out(64'hFFFF, 2'd1, 1'b0, "R7 second");
        drive(64'h7F, 2'd0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out(64'h7F, 2'd0, 1'b1, "R7 third");
    endtask

    task automatic t_hold;
        logic [63:0] keep_res;
        logic [5:0]  keep_flg;
        run_vec(64'h0000_0000_0000_00A5, 2'd0, 1'b1, "R8 setup");
        keep_res = out_result;
        keep_flg = out_flags;
        in_operand = 64'h7F;
        in_carry   = 1'b0;
        @(negedge clk);
        check({63'd0, out_valid}, 64'd0, "R8 valid low when idle");
        check(out_result, keep_res, "R8 result held");
        check({58'd0, out_flags}, {58'd0, keep_flg}, "R8 flags held");
        @(negedge clk);
        check(out_result, keep_res, "R8 result held 2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_wrap();
        t_overflow();
        t_aux_parity();
        t_mask();
        t_back_to_back();
        t_hold();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule